// File: doc/BRIEF.md
# Bit-Pipelined Ripple-Carry Adder

This block adds two unsigned operands with a carry chain that is cut by a register after every bit position. Each rank of the pipeline holds one 1-bit full adder, so the clock period only has to cover a single full-adder delay plus register overhead, not the whole ripple path. The carry entering the lowest bit is fixed at zero. The carry leaving the top bit is presented as a separate carry output.

Operand bits of higher significance are held back in skew registers so that each bit meets the carry from the bit below in the cycle that carry is produced. Sum bits that are finished early are held in deskew registers, so every bit of one result leaves in the same cycle. A valid flag travels alongside the data. A new operand pair may be offered on every clock and one result leaves on every clock once the pipeline is full. The block has no stall or backpressure: each accepted pair leaves a fixed number of cycles later.

Top module: `bitpipe_adder`

## Requirements
- R1: When `out_valid` is high, `{out_carry, out_sum}` equals the (WIDTH+1)-bit unsigned sum of the operand pair that produced it, with all WIDTH sum bits coming from that same pair.
- R2: A pair sampled with `in_valid` high on rising edge n appears with `out_valid` high after rising edge n+WIDTH-1, which is WIDTH rising edges counting the capture edge (32 for the default width).
- R3: Pairs offered on consecutive clocks come out on consecutive clocks, in order, with no gap and no loss.
- R4: An input cycle with `in_valid` low yields a cycle with `out_valid` low WIDTH edges later, and `out_valid` stays low for the first WIDTH edges after reset is released.
- R5: While `rst_n` is low, `out_valid`, `out_sum` and `out_carry` are all 0, and pairs in flight when reset is asserted never appear.
- R6: A carry generated in bit 0 ripples through every stage: all-ones plus one gives `out_sum` = 0 and `out_carry` = 1.
- R7: The carry into bit 0 is zero: 0 plus 0 gives `out_sum` = 0 and `out_carry` = 0, and all-ones plus zero gives all-ones with `out_carry` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | High when `in_a`/`in_b` carry a pair to add |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| out_valid | output | 1 | High when `out_sum`/`out_carry` carry a result |
| out_sum | output | WIDTH | Sum bits of the result |
| out_carry | output | 1 | Carry out of the top bit |

## Verification
The bench goes after full-length carry ripples (all-ones plus one, both operands all-ones, both top bits set). A design with a skew or deskew off by one cycle would mix bits of neighbouring pairs, and these cases show that as wrong high bits or a wrong carry. Back-to-back random pairs and patterns with gaps check that results keep their order and their exact latency: a valid flag with one rank too many or too few would shift every result by a cycle, and a lost bubble would show a result that was never offered. A reset in the middle of a stream checks that the pairs in flight are dropped rather than emerging after reset is released.

// File: rtl/bitpipe_pkg.sv
package bitpipe_pkg;

  // One-bit full adder written as gate equations; returns {carry, sum}.
  function automatic logic [1:0] fa_eval(input logic x, input logic y, input logic ci);
    logic s;
    logic co;
    s  = x ^ y ^ ci;
    co = (x & y) | (ci & (x ^ y));
    return {co, s};
  endfunction

endpackage

// File: rtl/bitpipe_cell.sv
module bitpipe_cell
  import bitpipe_pkg::*;
(
  input  logic op_x,
  input  logic op_y,
  input  logic cin,
  output logic sum,
  output logic cout
);

  assign {cout, sum} = fa_eval(op_x, op_y, cin);

  // Gate equations against plain arithmetic.
  always_comb begin
    if (!$isunknown({op_x, op_y, cin})) begin
      AST_CELL_ARITH: assert ({cout, sum} == (2'(op_x) + 2'(op_y) + 2'(cin))); // R1
    end
  end

endmodule

// File: rtl/bitpipe_stage.sv
module bitpipe_stage #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_d,
  input  logic             c_d,
  input  logic [WIDTH-1:0] a_d,
  input  logic [WIDTH-1:0] b_d,
  input  logic [WIDTH-1:0] s_d,
  output logic             v_q,
  output logic             c_q,
  output logic [WIDTH-1:0] a_q,
  output logic [WIDTH-1:0] b_q,
  output logic [WIDTH-1:0] s_q
);

  // Named internal events of this rank.
  logic cell_sum;
  logic cell_carry;

  // The operand bit this rank consumes sits at position 0 of the skew vectors.
  bitpipe_cell u_cell (
    .op_x (a_d[0]),
    .op_y (b_d[0]),
    .cin  (c_d),
    .sum  (cell_sum),
    .cout (cell_carry)
  );

  // Skew: remaining operand bits shift down one place per rank.
  // Deskew: finished sum bits enter at the top and shift down one place per rank.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      c_q <= 1'b0;
      a_q <= '0;
      b_q <= '0;
      s_q <= '0;
    end else begin
      v_q <= v_d;
      c_q <= cell_carry;
      a_q <= {1'b0, a_d[WIDTH-1:1]};
      b_q <= {1'b0, b_d[WIDTH-1:1]};
      s_q <= {cell_sum, s_d[WIDTH-1:1]};
    end
  end

  // The valid flag advances exactly one rank per clock.
  AST_VALID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (v_q == $past(v_d))); // R2

  // The slot dropped by the deskew shift is always empty on arrival.
  AST_SUM_SLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (s_d[0] == 1'b0)); // R1

endmodule

// File: rtl/bitpipe_adder.sv
module bitpipe_adder #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_sum,
  output logic             out_carry
);

  localparam int unsigned RANKS = WIDTH;
  localparam int unsigned CNT_W = $clog2(RANKS + 1);

  logic [RANKS-1:0] rk_v;
  logic [RANKS-1:0] rk_c;
  logic [WIDTH-1:0] rk_a [RANKS];
  logic [WIDTH-1:0] rk_b [RANKS];
  logic [WIDTH-1:0] rk_s [RANKS];

  for (genvar k = 0; k < RANKS; k++) begin : g_rank
    logic             v_in;
    logic             c_in;
    logic [WIDTH-1:0] a_in;
    logic [WIDTH-1:0] b_in;
    logic [WIDTH-1:0] s_in;

    if (k == 0) begin : g_head
      assign v_in = in_valid;
      assign c_in = 1'b0;          // carry into bit 0 is fixed at zero
      assign a_in = in_a;
      assign b_in = in_b;
      assign s_in = '0;
    end else begin : g_body
      assign v_in = rk_v[k-1];
      assign c_in = rk_c[k-1];
      assign a_in = rk_a[k-1];
      assign b_in = rk_b[k-1];
      assign s_in = rk_s[k-1];
    end

    bitpipe_stage #(.WIDTH(WIDTH)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .v_d   (v_in),
      .c_d   (c_in),
      .a_d   (a_in),
      .b_d   (b_in),
      .s_d   (s_in),
      .v_q   (rk_v[k]),
      .c_q   (rk_c[k]),
      .a_q   (rk_a[k]),
      .b_q   (rk_b[k]),
      .s_q   (rk_s[k])
    );
  end

  assign out_valid = rk_v[RANKS-1];
  assign out_carry = rk_c[RANKS-1];
  assign out_sum   = rk_s[RANKS-1];

  // Edges since reset release, saturating at the pipeline depth.
  logic [CNT_W-1:0] fill_cnt;
  logic             pipe_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt <= '0;
    end else if (!pipe_full) begin
      fill_cnt <= fill_cnt + 1'b1;
    end
  end

  assign pipe_full = (fill_cnt == CNT_W'(RANKS));

  // No result can leave before the pipeline has had time to fill.
  AST_FILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_full |-> !out_valid); // R4

  // Every operand bit has been consumed by the time a result leaves.
  AST_OPERANDS_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((rk_a[RANKS-1] == '0) && (rk_b[RANKS-1] == '0))); // R1

  // A valid result carries no unknown bits.
  AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown({out_carry, out_sum})); // R1

  // Reset holds the result outputs at zero.
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && (out_sum == '0) && !out_carry)); // R5

endmodule

// File: tb/bitpipe_adder_bench.sv
`timescale 1ns/1ps
module bitpipe_adder_bench;

  localparam int unsigned W = 32;
  localparam int unsigned NVEC = 10;

  // {a, b} pairs; expected results are computed below.
  localparam logic [63:0] VEC [NVEC] = '{
    {32'h0000_0000, 32'h0000_0000},   // R7 zero plus zero
    {32'hFFFF_FFFF, 32'h0000_0001},   // R6 full ripple
    {32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'h8000_0000, 32'h8000_0000},
    {32'h1234_5678, 32'h8765_4321},
    {32'hAAAA_AAAA, 32'h5555_5555},
    {32'h7FFF_FFFF, 32'h0000_0001},
    {32'hDEAD_BEEF, 32'hCAFE_BABE},
    {32'h0000_0000, 32'hFFFF_FFFF},   // R7 no carry in
    {32'h0F0F_0F0F, 32'hF0F0_F0F1}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         out_valid;
  logic [W-1:0] out_sum;
  logic         out_carry;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [W:0] exp_q [$];
  int         stamp_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;

  bitpipe_adder #(.WIDTH(W)) u_bitpipe_adder (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_sum   (out_sum),
    .out_carry (out_carry)
  );

  function automatic logic [W:0] ref_add(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] r;
    logic       c;
    c = 1'b0;
    for (int i = 0; i < W; i++) begin
      r[i] = a[i] ^ b[i] ^ c;
      c    = (a[i] + b[i] + c) > 1;
    end
    r[W] = c;
    return r;
  endfunction

  // Called at a falling edge: compare outputs with the reference queue.
  task automatic check_out();
    if (stamp_q.size() > 0 && stamp_q[0] + W == cyc) begin
      checks++;
      if (out_valid !== 1'b1) begin
        fails++;
        $display("FAIL R2 %s: out_valid=%b expected 1 at cycle %0d", tag_q[0], out_valid, cyc);
      end
      checks++;
      if ({out_carry, out_sum} !== exp_q[0]) begin
        fails++;
        $display("FAIL R1 %s: result=%h expected %h", tag_q[0], {out_carry, out_sum}, exp_q[0]);
      end
      void'(exp_q.pop_front());
      void'(stamp_q.pop_front());
      void'(tag_q.pop_front());
    end else begin
      checks++;
      if (out_valid !== 1'b0) begin
        fails++;
        $display("FAIL R4 idle slot: out_valid=%b expected 0 at cycle %0d", out_valid, cyc);
      end
    end
  endtask

  task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    @(negedge clk);
    check_out();
    in_valid = v;
    in_a     = a;
    in_b     = b;
    if (v) begin
      exp_q.push_back(ref_add(a, b));
      stamp_q.push_back(cyc);
      tag_q.push_back(tag);
    end
    cyc++;
  endtask

  task automatic drain();
    for (int i = 0; i < W + 2; i++) step(1'b0, '0, '0, "drain");
  endtask

  task automatic check_reset_zero(input string where);
    checks++;
    if (out_valid !== 1'b0 || out_sum !== '0 || out_carry !== 1'b0) begin
      fails++;
      $display("FAIL R5 %s: {valid,carry,sum}=%b_%b_%h expected 0_0_0",
               where, out_valid, out_carry, out_sum);
    end
  endtask

  initial begin
    // R5: reset state
    repeat (3) @(negedge clk);
    check_reset_zero("power-on reset");
    rst_n = 1'b1;

    // R4: no result during fill
    for (int i = 0; i < W + 2; i++) step(1'b0, '0, '0, "R4 fill");

    // R2: one isolated pair, exact latency
    step(1'b1, 32'h0000_00FF, 32'h0000_0001, "R2 single");
    drain();

    // R1/R3: table walked back to back
    for (int i = 0; i < NVEC; i++) step(1'b1, VEC[i][63:32], VEC[i][31:0], "R1 table");
    drain();

    // R6: full ripple, directed
    step(1'b1, 32'hFFFF_FFFF, 32'h0000_0001, "R6 ripple");
    step(1'b1, 32'h0000_0001, 32'hFFFF_FFFF, "R6 ripple swapped");
    // R7: carry in is zero
    step(1'b1, 32'h0000_0000, 32'h0000_0000, "R7 zero");
    step(1'b1, 32'hFFFF_FFFF, 32'h0000_0000, "R7 ones plus zero");
    drain();

    // R3: long random back-to-back stream
    for (int i = 0; i < 300; i++) step(1'b1, W'($urandom), W'($urandom), "R3 stream");
    drain();

    // R4: bubbles in several patterns
    for (int i = 0; i < 120; i++) step((i % 2) == 0, W'($urandom), W'($urandom), "R4 alt");
    for (int i = 0; i < 120; i++) step((i % 3) != 1, W'($urandom), W'($urandom), "R4 gap3");
    for (int i = 0; i < 120; i++) step(1'($urandom), W'($urandom), W'($urandom), "R4 random gaps");
    drain();

    // R5: reset in the middle of a stream drops pairs in flight
    for (int i = 0; i < W / 2; i++) step(1'b1, W'($urandom), W'($urandom), "R5 before reset");
    @(negedge clk);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    #1;
    check_reset_zero("mid-stream reset");
    exp_q.delete();
    stamp_q.delete();
    tag_q.delete();
    repeat (2) @(negedge clk);
    check_reset_zero("reset held");
    rst_n = 1'b1;
    cyc += 3;
    for (int i = 0; i < W + 4; i++) step(1'b0, '0, '0, "R5 after reset");
    for (int i = 0; i < 40; i++) step(1'b1, W'($urandom), W'($urandom), "R3 after reset");
    drain();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule